// File: doc/BRIEF.md
# Queue-Pair DMA Channel Controller

This block is the control side of one memory-to-memory DMA channel that software drives through two rings in memory. One ring carries submissions and the other carries completions. Software writes the channel registers over a simple 32-bit register bus with separate write and read address ports. It programs each ring's 64-bit base as two 32-bit words and each ring's size. It then starts work by writing a new submission tail index, the doorbell.

The block compares an internal submission head with that tail. For every entry still pending it presents the entry's index to a downstream descriptor fetch and copy engine, using a valid/ready handshake. Separate enable and pause bits decide whether new indexes may go out. A self-clearing reset bit rewinds the channel. A 4-bit state field lets software poll whether the channel is idle, running, paused or resetting. The data mover itself, the completion writes and bus mastering are outside this block.

Top module: `dma_qchan_ctrl`

## Requirements
- R1: After the synchronous reset, the state field reads 0 (idle) and `iss_valid` is low. Both depth registers read 2^IDX_W−1, which is 1023 by default. The submission tail and the completion head read 0.
- R2: The register map is byte-addressed on `wr_addr` and `rd_addr`:
  - The four ring base words read back as written, all 32 bits: submission low 0x00, submission high 0x04, completion low 0x10, completion high 0x14.
  - The depth registers at 0x08 (submission) and 0x18 (completion) hold the entry count minus one in bits [IDX_W-1:0].
  - Control word 0x20 has enable at bit 0 and pause at bit 4.
  - Any unmapped address reads 0.
- R3: A write to the submission tail at 0x0C is the trigger for new work. If the channel is enabled and not paused, `iss_valid` rises on the clock edge after the write, with `iss_idx` equal to the internal head.
- R4: While `iss_valid` is high and `iss_ready` is low, `iss_valid` and `iss_idx` hold. Each accepted index advances the head by one. The next pending index is presented in the very next cycle, so one index is issued per cycle.
- R5: The head wraps to 0 after it reaches the value held in the submission depth register, so indexes run modulo depth+1.
- R6: While pause is set or enable is clear, no new index is raised on `iss_valid`. An index already presented stays valid until it is accepted.
- R7: Bits [3:0] at 0x30 hold the channel state:
  - RUN = 1 when the channel is enabled, not paused and has head ≠ tail.
  - Otherwise PAUSED = 2 if pause is set.
  - Otherwise IDLE = 0.
- R8: Writing 1 to bit 0 of 0x24 starts a reset that lasts one cycle. During that cycle bit 0 of 0x24 reads 1 and the state field reads 3 (resetting). After it, bit 0 reads 0, the submission tail, the completion head and the internal head are 0, and `iss_valid` is low.
- R9: After a reset, with enable set and pause clear, the channel settles in IDLE (0).
- R10: The completion head register at 0x1C reads back as written. Issuing indexes does not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte address |
| rd_data | output | 32 | Register read data, combinational from `rd_addr` |
| iss_valid | output | 1 | A pending submission index is presented |
| iss_idx | output | IDX_W | Submission ring index being presented |
| iss_ready | input | 1 | Downstream engine accepts the presented index |

## Verification
A head pointer that drifts from its true value shows at `iss_idx` on the next accepted handshake. It also corrupts the pending test, so the channel either issues past the tail or stalls. A wrong head also makes the RUN/IDLE field at 0x30 disagree with the number of entries still pending in the same cycle. A stuck reset pulse or a missed pointer clear shows two cycles after the reset write, as a state of 3 or a non-zero tail read. The bench steps a behavioural model of the ring every clock and compares the handshake outputs and the polled state against it on every cycle. Any divergence is therefore caught in the cycle it first appears.

// File: rtl/dma_qchan_pkg.sv
package dma_qchan_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    // register offsets inside the channel window
    localparam logic [ADDR_W-1:0] OFF_SQ_BASE_LO = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_SQ_BASE_HI = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_SQ_DEPTH   = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_SQ_TAIL    = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_CQ_BASE_LO = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_CQ_BASE_HI = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_CQ_DEPTH   = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_CQ_HEAD    = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_CTRL_RUN   = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_CTRL_RST   = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_STATE      = 8'h30;

    localparam int BIT_ENABLE = 0;
    localparam int BIT_PAUSE  = 4;
    localparam int BIT_RESET  = 0;

    typedef enum logic [3:0] {
        CH_IDLE    = 4'd0,
        CH_RUN     = 4'd1,
        CH_PAUSED  = 4'd2,
        CH_RESET   = 4'd3
    } chan_state_e;

    typedef struct packed {
        logic enable;
        logic pause;
        logic flush;
    } chan_ctrl_t;

endpackage

// File: rtl/dma_qchan_regs.sv
module dma_qchan_regs
    import dma_qchan_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  chan_state_e         state,
    output chan_ctrl_t          ctrl,
    output logic [IDX_W-1:0]    sq_last,
    output logic [IDX_W-1:0]    sq_tail
);

    localparam logic [IDX_W-1:0] LAST_RST = {IDX_W{1'b1}};

    logic [DATA_W-1:0] sq_base_lo, sq_base_hi, cq_base_lo, cq_base_hi;
    logic [IDX_W-1:0]  sq_last_q, cq_last_q, sq_tail_q, cq_head_q;
    logic              en_q, pause_q, flush_q;

    logic rst_write;
    assign rst_write = wr_en && (wr_addr == OFF_CTRL_RST) && wr_data[BIT_RESET];

    always_ff @(posedge clk) begin
        if (rst) begin
            sq_base_lo <= '0;
            sq_base_hi <= '0;
            cq_base_lo <= '0;
            cq_base_hi <= '0;
            sq_last_q  <= LAST_RST;
            cq_last_q  <= LAST_RST;
            sq_tail_q  <= '0;
            cq_head_q  <= '0;
            en_q       <= 1'b0;
            pause_q    <= 1'b0;
            flush_q    <= 1'b0;
        end else begin
            flush_q <= rst_write;
            if (wr_en) begin
                case (wr_addr)
                    OFF_SQ_BASE_LO: sq_base_lo <= wr_data;
                    OFF_SQ_BASE_HI: sq_base_hi <= wr_data;
                    OFF_CQ_BASE_LO: cq_base_lo <= wr_data;
                    OFF_CQ_BASE_HI: cq_base_hi <= wr_data;
                    OFF_SQ_DEPTH:   sq_last_q  <= wr_data[IDX_W-1:0];
                    OFF_CQ_DEPTH:   cq_last_q  <= wr_data[IDX_W-1:0];
                    OFF_SQ_TAIL:    sq_tail_q  <= wr_data[IDX_W-1:0];
                    OFF_CQ_HEAD:    cq_head_q  <= wr_data[IDX_W-1:0];
                    OFF_CTRL_RUN: begin
                        en_q    <= wr_data[BIT_ENABLE];
                        pause_q <= wr_data[BIT_PAUSE];
                    end
                    default: ;
                endcase
            end
            // the reset cycle wins over any pointer write landing in it
            if (flush_q) begin
                sq_tail_q <= '0;
                cq_head_q <= '0;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            OFF_SQ_BASE_LO: rd_data = sq_base_lo;
            OFF_SQ_BASE_HI: rd_data = sq_base_hi;
            OFF_CQ_BASE_LO: rd_data = cq_base_lo;
            OFF_CQ_BASE_HI: rd_data = cq_base_hi;
            OFF_SQ_DEPTH:   rd_data = DATA_W'(sq_last_q);
            OFF_CQ_DEPTH:   rd_data = DATA_W'(cq_last_q);
            OFF_SQ_TAIL:    rd_data = DATA_W'(sq_tail_q);
            OFF_CQ_HEAD:    rd_data = DATA_W'(cq_head_q);
            OFF_CTRL_RUN:   rd_data = {27'd0, pause_q, 3'd0, en_q};
            OFF_CTRL_RST:   rd_data = {31'd0, flush_q};
            OFF_STATE:      rd_data = {28'd0, state};
            default:        rd_data = '0;
        endcase
    end

    assign ctrl.enable = en_q;
    assign ctrl.pause  = pause_q;
    assign ctrl.flush  = flush_q;
    assign sq_last     = sq_last_q;
    assign sq_tail     = sq_tail_q;

    // R8: the reset bit lasts one cycle unless written again
    a_r8_reset_self_clears: assert property (@(posedge clk) disable iff (rst)
        flush_q && !rst_write |=> !flush_q);

    // R8: pointers read zero after the reset cycle
    a_r8_pointers_cleared: assert property (@(posedge clk) disable iff (rst)
        flush_q |=> (sq_tail_q == '0) && (cq_head_q == '0));

endmodule

// File: rtl/dma_qchan_issue.sv
module dma_qchan_issue
    import dma_qchan_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  chan_ctrl_t        ctrl,
    input  logic [IDX_W-1:0]  sq_last,
    input  logic [IDX_W-1:0]  sq_tail,
    input  logic              iss_ready,
    output logic              iss_valid,
    output logic [IDX_W-1:0]  iss_idx,
    output chan_state_e       state
);

    logic             valid_q;
    logic [IDX_W-1:0] head_q, idx_q, head_nx;
    logic             accept, hold, may_issue, pending;

    function automatic logic [IDX_W-1:0] ring_step(input logic [IDX_W-1:0] cur,
                                                   input logic [IDX_W-1:0] last);
        return (cur == last) ? '0 : cur + 1'b1;
    endfunction

    assign accept    = valid_q && iss_ready;
    assign hold      = valid_q && !iss_ready;
    assign may_issue = ctrl.enable && !ctrl.pause;
    assign head_nx   = accept ? ring_step(head_q, sq_last) : head_q;
    assign pending   = (head_q != sq_tail);

    always_ff @(posedge clk) begin
        if (rst || ctrl.flush) begin
            valid_q <= 1'b0;
            head_q  <= '0;
            idx_q   <= '0;
        end else if (!hold) begin
            head_q  <= head_nx;
            idx_q   <= head_nx;
            valid_q <= may_issue && (head_nx != sq_tail);
        end
    end

    always_comb begin
        if (ctrl.flush)
            state = CH_RESET;
        else if (may_issue && pending)
            state = CH_RUN;
        else if (ctrl.pause)
            state = CH_PAUSED;
        else
            state = CH_IDLE;
    end

    assign iss_valid = valid_q;
    assign iss_idx   = idx_q;

    // R4: a presented index is held until taken
    a_r4_hold_until_taken: assert property (@(posedge clk) disable iff (rst)
        valid_q && !iss_ready && !ctrl.flush |=> valid_q && $stable(idx_q));

    // R6: nothing new is raised while stopped
    a_r6_no_new_issue: assert property (@(posedge clk) disable iff (rst)
        !valid_q && (!ctrl.enable || ctrl.pause) |=> !valid_q);

    // R3: a fresh index appears only with the channel allowed to run
    a_r3_start_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_q) |-> $past(ctrl.enable && !ctrl.pause));

    // R5: accepting the last slot wraps the head to zero
    a_r5_head_wraps: assert property (@(posedge clk) disable iff (rst)
        accept && !ctrl.flush && (head_q == sq_last) |=> head_q == '0);

    // R8: the reset cycle drops the presented index and rewinds the head
    a_r8_issue_dropped: assert property (@(posedge clk) disable iff (rst)
        ctrl.flush |=> !valid_q && (head_q == '0));

endmodule

// File: rtl/dma_qchan_ctrl.sv
module dma_qchan_ctrl
    import dma_qchan_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [7:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic              iss_valid,
    output logic [IDX_W-1:0]  iss_idx,
    input  logic              iss_ready
);

    chan_ctrl_t       ctrl;
    chan_state_e      state;
    logic [IDX_W-1:0] sq_last, sq_tail;

    dma_qchan_regs #(.IDX_W(IDX_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .state   (state),
        .ctrl    (ctrl),
        .sq_last (sq_last),
        .sq_tail (sq_tail)
    );

    dma_qchan_issue #(.IDX_W(IDX_W)) u_issue (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .sq_last   (sq_last),
        .sq_tail   (sq_tail),
        .iss_ready (iss_ready),
        .iss_valid (iss_valid),
        .iss_idx   (iss_idx),
        .state     (state)
    );

endmodule

// File: tb/dma_qchan_ctrl_tb_top.sv
module dma_qchan_ctrl_tb_top;

    localparam int IDX_W = 10;
    localparam int MASK  = (1 << IDX_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [7:0]       wr_addr = '0;
    logic [31:0]      wr_data = '0;
    logic [7:0]       rd_addr = 8'h30;
    logic [31:0]      rd_data;
    logic             iss_valid;
    logic [IDX_W-1:0] iss_idx;
    logic             iss_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    dma_qchan_ctrl #(.IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .iss_valid(iss_valid),
        .iss_idx(iss_idx), .iss_ready(iss_ready)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // ---------------- behavioural ring model ----------------
    int m_en, m_pause, m_rst, m_tail, m_head, m_valid, m_idx, m_last, m_chead;

    always @(posedge clk) begin
        int old_rst;
        if (rst) begin
            m_en = 0; m_pause = 0; m_rst = 0; m_tail = 0; m_head = 0;
            m_valid = 0; m_idx = 0; m_last = MASK; m_chead = 0;
        end else begin
            old_rst = m_rst;
            if (old_rst != 0) begin
                m_head = 0; m_valid = 0; m_idx = 0;
            end else if (!(m_valid != 0 && !iss_ready)) begin
                if (m_valid != 0) m_head = (m_head == m_last) ? 0 : m_head + 1;
                m_idx = m_head;
                m_valid = (m_en != 0 && m_pause == 0 && m_head != m_tail) ? 1 : 0;
            end
            m_rst = 0;
            if (wr_en) begin
                case (wr_addr)
                    8'h08: m_last = int'(wr_data) & MASK;
                    8'h0C: m_tail = int'(wr_data) & MASK;
                    8'h1C: m_chead = int'(wr_data) & MASK;
                    8'h20: begin m_en = int'(wr_data[0]); m_pause = int'(wr_data[4]); end
                    8'h24: m_rst = int'(wr_data[0]);
                    default: ;
                endcase
            end
            if (old_rst != 0) begin m_tail = 0; m_chead = 0; end
        end
    end

    function automatic int model_state();
        if (m_rst != 0) return 3;
        if (m_en != 0 && m_pause == 0 && m_head != m_tail) return 1;
        if (m_pause != 0) return 2;
        return 0;
    endfunction

    // compare every cycle, 3 ns after the edge
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (!rst) begin
                chk("R4 model valid", 32'(iss_valid), 32'(m_valid));
                if (iss_valid) chk("R4 model index", 32'(iss_idx), 32'(m_idx));
                if (rd_addr == 8'h30) chk("R7 model state", rd_data, 32'(model_state()));
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] v);
        rd_addr = a;
        #1 v = rd_data;
        #1 rd_addr = 8'h30;
    endtask

    task automatic after_edge();
        @(posedge clk);
        #3;
    endtask

    initial begin
        logic [31:0] v;
        int tail_sw;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        peek(8'h30, v); chk("R1 state idle", v, 0);
        chk("R1 valid low", 32'(iss_valid), 0);
        peek(8'h08, v); chk("R1 sq depth", v, MASK);
        peek(8'h18, v); chk("R1 cq depth", v, MASK);
        peek(8'h0C, v); chk("R1 tail zero", v, 0);
        peek(8'h1C, v); chk("R1 cq head zero", v, 0);

        // R2 register readback
        wr(8'h00, 32'hA5A5_0001); wr(8'h04, 32'h0000_00F2);
        wr(8'h10, 32'h1234_5678); wr(8'h14, 32'hFFFF_0003);
        wr(8'h18, 32'h0000_01FF);
        wr(8'h20, 32'h0000_0011);
        peek(8'h00, v); chk("R2 sq base lo", v, 32'hA5A5_0001);
        peek(8'h04, v); chk("R2 sq base hi", v, 32'h0000_00F2);
        peek(8'h10, v); chk("R2 cq base lo", v, 32'h1234_5678);
        peek(8'h14, v); chk("R2 cq base hi", v, 32'hFFFF_0003);
        peek(8'h18, v); chk("R2 cq depth", v, 32'h1FF);
        peek(8'h20, v); chk("R2 ctrl bits", v, 32'h11);
        peek(8'h28, v); chk("R2 unmapped", v, 0);
        wr(8'h20, 32'h0);

        // R10 completion head
        wr(8'h1C, 32'h55);
        peek(8'h1C, v); chk("R10 cq head readback", v, 32'h55);

        // R3 doorbell starts work
        wr(8'h20, 32'h1);
        wr(8'h0C, 32'd3);
        after_edge();
        chk("R3 valid after doorbell", 32'(iss_valid), 1);
        chk("R3 first index", 32'(iss_idx), 0);
        peek(8'h30, v); chk("R7 running", v, 1);

        // R4 hold while not ready, then one per cycle
        repeat (3) after_edge();
        chk("R4 held valid", 32'(iss_valid), 1);
        chk("R4 held index", 32'(iss_idx), 0);
        @(negedge clk); iss_ready = 1'b1;
        after_edge(); chk("R4 next index", 32'(iss_idx), 1);
        after_edge(); chk("R4 next index", 32'(iss_idx), 2);
        after_edge(); chk("R4 drained", 32'(iss_valid), 0);
        @(negedge clk); iss_ready = 1'b0;
        peek(8'h30, v); chk("R7 idle when drained", v, 0);
        peek(8'h1C, v); chk("R10 cq head untouched", v, 32'h55);

        // R6 pause and disable
        wr(8'h20, 32'h11);
        wr(8'h0C, 32'd5);
        repeat (3) after_edge();
        chk("R6 no issue while paused", 32'(iss_valid), 0);
        peek(8'h30, v); chk("R7 paused", v, 2);
        wr(8'h20, 32'h1);
        after_edge();
        chk("R6 resume issues", 32'(iss_valid), 1);
        chk("R6 resume index", 32'(iss_idx), 3);
        wr(8'h20, 32'h0);
        after_edge();
        chk("R6 presented index kept", 32'(iss_valid), 1);
        @(negedge clk); iss_ready = 1'b1;
        after_edge();
        @(negedge clk); iss_ready = 1'b0;
        after_edge();
        chk("R6 no issue while disabled", 32'(iss_valid), 0);

        // R8 reset pulse
        wr(8'h20, 32'h1);
        @(negedge clk); iss_ready = 1'b0;
        wr(8'h24, 32'h1);
        peek(8'h24, v); chk("R8 reset bit set", v, 1);
        peek(8'h30, v); chk("R8 resetting state", v, 3);
        @(negedge clk);
        peek(8'h24, v); chk("R8 reset bit cleared", v, 0);
        peek(8'h0C, v); chk("R8 tail cleared", v, 0);
        peek(8'h1C, v); chk("R8 cq head cleared", v, 0);
        chk("R8 issue dropped", 32'(iss_valid), 0);
        repeat (2) @(negedge clk);
        peek(8'h30, v); chk("R9 idle after reset", v, 0);

        // R5 wrap with a small ring
        wr(8'h08, 32'd7);
        iss_ready = 1'b1;
        wr(8'h0C, 32'd6);
        repeat (10) @(negedge clk);
        wr(8'h0C, 32'd2);
        after_edge(); chk("R5 index six", 32'(iss_idx), 6);
        after_edge(); chk("R5 index seven", 32'(iss_idx), 7);
        after_edge(); chk("R5 wrap to zero", 32'(iss_idx), 0);
        after_edge(); chk("R5 index one", 32'(iss_idx), 1);
        after_edge(); chk("R5 ring drained", 32'(iss_valid), 0);

        // mixed traffic, checked by the model each cycle
        tail_sw = 2;
        for (int n = 0; n < 1500; n++) begin
            @(negedge clk);
            iss_ready = ($urandom % 3) != 0;
            case ($urandom % 16)
                0: begin tail_sw = (tail_sw + 1 + ($urandom % 4)) % 8; wr_en = 1'b1; wr_addr = 8'h0C; wr_data = 32'(tail_sw); end
                1: begin wr_en = 1'b1; wr_addr = 8'h20; wr_data = ($urandom % 4 == 0) ? 32'h11 : 32'h1; end
                2: begin wr_en = 1'b1; wr_addr = 8'h20; wr_data = 32'h1; end
                3: if ($urandom % 8 == 0) begin wr_en = 1'b1; wr_addr = 8'h24; wr_data = 32'h1; tail_sw = 0; end
                default: wr_en = 1'b0;
            endcase
            @(negedge clk);
            wr_en = 1'b0;
        end

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule